// File: doc/BRIEF.md
# Demand-Driven Two-Way Junction Light Controller

This block decides which of two crossing roads holds the green at a junction where each lamp is only green or red. It keeps exactly one road green at all times. It re-examines that choice only at a fixed decision interval. Between decisions the lamps are frozen.

At each decision the controller looks at the car detector of the road that is currently red. If a car is waiting there, the green passes to that road. Otherwise the current green is kept. The detector of the road that already has the green plays no part.

A down-counter inside the block produces the decision pulse once every `DECISION_CYCLES` clocks. The default is thirty seconds of a 50 MHz clock. A synchronous reset gives the green to the north-south road and restarts the interval.

Top module: `junction_light_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the controller enters the north-south green phase (`green_ns`=1, `green_ew`=0) and the decision interval restarts.
- R2: In every cycle after reset, exactly one of `green_ns` and `green_ew` is high.
- R3: A decision is taken at the DECISION_CYCLES-th rising edge after the last reset edge, and then at every DECISION_CYCLES-th edge after that. A lamp change caused by a decision is visible right after that edge.
- R4: At a decision in the north-south phase with `car_ew`=1, the east-west phase follows, whatever the value of `car_ns`.
- R5: At a decision in the north-south phase with `car_ew`=0, the north-south phase is kept.
- R6: At a decision in the east-west phase with `car_ns`=1, the north-south phase follows, whatever the value of `car_ew`.
- R7: At a decision in the east-west phase with `car_ns`=0, the east-west phase is kept.
- R8: Detector activity on edges that are not decision edges has no effect on the lamps. This holds even for a pulse that ends just before the decision edge.
- R9: A reset asserted in the middle of an interval discards the partial interval. The next decision falls a full DECISION_CYCLES edges after the reset edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| car_ns | input | 1 | High while a car is present on the north-south road |
| car_ew | input | 1 | High while a car is present on the east-west road |
| green_ns | output | 1 | North-south lamp green (red when low) |
| green_ew | output | 1 | East-west lamp green (red when low) |

## Verification
The bench holds both detectors high across a first decision. An off-by-one interval counter would show the east-west green one edge early or one edge late. A design that also checked the detector of the road already green would fail to switch in that case.

A detector pulse that stays high for a whole interval but drops one cycle before the decision edge catches a design that latches detector events instead of sampling at the decision edge. A reset two cycles into an interval, followed by a waiting car, exposes a timer that does not reload on reset: its first decision would come early. Every cycle is also compared against a behavioural model, so a lamp that goes dark, or two greens at once, is reported wherever it occurs.

// File: rtl/jlc_pkg.sv
package jlc_pkg;

  typedef enum logic {
    PH_NS = 1'b0,
    PH_EW = 1'b1
  } phase_t;

  // The road that is red hands the green over only when its own car is waiting.
  function automatic phase_t next_phase(phase_t cur, logic ns_car, logic ew_car);
    phase_t nxt;
    nxt = cur;
    case (cur)
      PH_NS:   if (ew_car) nxt = PH_EW;
      PH_EW:   if (ns_car) nxt = PH_NS;
      default: nxt = PH_NS;
    endcase
    return nxt;
  endfunction

  function automatic int unsigned count_width(int unsigned cycles);
    return (cycles > 1) ? $clog2(cycles) : 1;
  endfunction

endpackage

// File: rtl/jlc_interval_timer.sv
module jlc_interval_timer #(
  parameter int unsigned DECISION_CYCLES = 1_500_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned CNT_W = jlc_pkg::count_width(DECISION_CYCLES);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(DECISION_CYCLES - 1);

  logic [CNT_W-1:0] remain;

  assign tick = (remain == '0);

  always_ff @(posedge clk) begin
    if (rst)       remain <= RELOAD;
    else if (tick) remain <= RELOAD;
    else           remain <= remain - 1'b1;
  end
endmodule

// File: rtl/jlc_phase_reg.sv
module jlc_phase_reg
  import jlc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic decide,
  input  logic car_ns,
  input  logic car_ew,
  output logic green_ns,
  output logic green_ew
);
  phase_t phase_q;
  phase_t phase_d;

  always_comb begin
    phase_d = phase_q;
    if (decide) phase_d = next_phase(phase_q, car_ns, car_ew);
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_NS;
    else     phase_q <= phase_d;
  end

  assign green_ns = (phase_q == PH_NS);
  assign green_ew = (phase_q == PH_EW);
endmodule

// File: rtl/junction_light_ctrl.sv
module junction_light_ctrl #(
  parameter int unsigned DECISION_CYCLES = 1_500_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic car_ns,
  input  logic car_ew,
  output logic green_ns,
  output logic green_ew
);
  logic decide_tick;

  jlc_interval_timer #(.DECISION_CYCLES(DECISION_CYCLES)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .tick (decide_tick)
  );

  jlc_phase_reg u_phase (
    .clk      (clk),
    .rst      (rst),
    .decide   (decide_tick),
    .car_ns   (car_ns),
    .car_ew   (car_ew),
    .green_ns (green_ns),
    .green_ew (green_ew)
  );
endmodule

// File: rtl/junction_light_ctrl_chk.sv
module junction_light_ctrl_chk #(
  parameter int unsigned DECISION_CYCLES = 1_500_000_000
) (
  input logic clk,
  input logic rst,
  input logic car_ns,
  input logic car_ew,
  input logic green_ns,
  input logic green_ew,
  input logic tick
);
  localparam int unsigned CNT_W = jlc_pkg::count_width(DECISION_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DECISION_CYCLES - 1);

  logic [CNT_W-1:0] since;

  always_ff @(posedge clk) begin
    if (rst)       since <= '0;
    else if (tick) since <= '0;
    else           since <= since + 1'b1;
  end

  p_reset_ns_r1: assert property (@(posedge clk) rst |=> (green_ns && !green_ew));

  p_one_green_r2: assert property (@(posedge clk) disable iff (rst)
    $countones({green_ns, green_ew}) == 1);

  p_tick_spacing_r3: assert property (@(posedge clk) disable iff (rst)
    tick == (since == LAST));

  p_ns_to_ew_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && green_ns && car_ew) |=> green_ew);

  p_ns_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && green_ns && !car_ew) |=> green_ns);

  p_ew_to_ns_r6: assert property (@(posedge clk) disable iff (rst)
    (tick && green_ew && car_ns) |=> green_ns);

  p_ew_keep_r7: assert property (@(posedge clk) disable iff (rst)
    (tick && green_ew && !car_ns) |=> green_ew);

  p_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(green_ns) && $stable(green_ew)));
endmodule

bind junction_light_ctrl junction_light_ctrl_chk #(.DECISION_CYCLES(DECISION_CYCLES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .car_ns   (car_ns),
  .car_ew   (car_ew),
  .green_ns (green_ns),
  .green_ew (green_ew),
  .tick     (decide_tick)
);

// File: tb/junction_light_ctrl_test.sv
module junction_light_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic car_ns = 1'b0;
  logic car_ew = 1'b0;
  logic green_ns, green_ew;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;
  string cur_req = "R1";

  // behavioural reference: count edges up, decide on the N-th
  int  edge_cnt = 0;
  bit  ref_ew = 1'b0;

  junction_light_ctrl #(.DECISION_CYCLES(N)) uut (
    .clk(clk), .rst(rst), .car_ns(car_ns), .car_ew(car_ew),
    .green_ns(green_ns), .green_ew(green_ew)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) begin
      edge_cnt <= 0;
      ref_ew   <= 1'b0;
      mon_on   <= 1'b1;
    end else if (edge_cnt == N - 1) begin
      edge_cnt <= 0;
      if (ref_ew) ref_ew <= car_ns ? 1'b0 : 1'b1;
      else        ref_ew <= car_ew ? 1'b1 : 1'b0;
    end else begin
      edge_cnt <= edge_cnt + 1;
    end
  end

  task automatic chk(string req, logic a_ns, logic a_ew, logic e_ns, logic e_ew);
    checks++;
    if (a_ns !== e_ns || a_ew !== e_ew) begin
      failures++;
      $display("FAIL %s: green_ns/green_ew = %b%b, expected %b%b at %0t",
               req, a_ns, a_ew, e_ns, e_ew, $time);
    end
  endtask

  // compare against the model every cycle
  always @(negedge clk) begin
    if (mon_on && !done) begin
      chk("R2", green_ns ^ green_ew, 1'b0, 1'b1, 1'b0);
      chk(cur_req, green_ns, green_ew, !ref_ew, ref_ew);
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    checks++;
    failures++;
    $display("FAIL watchdog: run did not complete, actual hung, expected done");
    finish_run();
  end

  initial begin
    // R1: reset state
    step(3);
    chk("R1", green_ns, green_ew, 1'b1, 1'b0);

    // R3/R4: both cars waiting, first decision on edge N after reset
    car_ns = 1'b1; car_ew = 1'b1;
    cur_req = "R3";
    rst = 1'b0;
    step(N - 1);
    chk("R3", green_ns, green_ew, 1'b1, 1'b0);
    step(1);
    chk("R4", green_ns, green_ew, 1'b0, 1'b1);

    // R6: car on north-south road, east-west car still present
    cur_req = "R6";
    step(N - 1);
    chk("R6", green_ns, green_ew, 1'b0, 1'b1);
    step(1);
    chk("R6", green_ns, green_ew, 1'b1, 1'b0);

    // R5: north-south green, no east-west car
    cur_req = "R5";
    car_ew = 1'b0; car_ns = 1'b1;
    step(N);
    chk("R5", green_ns, green_ew, 1'b1, 1'b0);

    // back to east-west
    cur_req = "R4";
    car_ns = 1'b0; car_ew = 1'b1;
    step(N);
    chk("R4", green_ns, green_ew, 1'b0, 1'b1);

    // R7: east-west green, no north-south car
    cur_req = "R7";
    step(N);
    chk("R7", green_ns, green_ew, 1'b0, 1'b1);

    // R8: north-south car present between decisions, gone at the decision edge
    cur_req = "R8";
    car_ew = 1'b0;
    car_ns = 1'b1;
    step(N - 1);
    chk("R8", green_ns, green_ew, 1'b0, 1'b1);
    car_ns = 1'b0;
    step(1);
    chk("R8", green_ns, green_ew, 1'b0, 1'b1);

    // R9: reset part-way through an interval
    cur_req = "R9";
    step(2);
    rst = 1'b1;
    step(1);
    chk("R1", green_ns, green_ew, 1'b1, 1'b0);
    car_ew = 1'b1;
    rst = 1'b0;
    step(N - 1);
    chk("R9", green_ns, green_ew, 1'b1, 1'b0);
    step(1);
    chk("R9", green_ns, green_ew, 1'b0, 1'b1);

    step(2);
    finish_run();
  end
endmodule